// File: doc/BRIEF.md
# Write-Protected SRAM Access Controller

This block is the control logic for a byte-wide static memory that a processor bus drives with the classic asynchronous controls: active-low chip select, output enable and write enable, plus a word address and a data bus. The data bus is split into separate inbound data, outbound data and an output-drive enable, so the pad ring builds the tri-state buffer. The controls are sampled on a system clock. The storage is a synchronous array. Its depth is a parameter, so simulation can use a short array, and address bits above that depth then alias onto it.

A write lasts for as long as both chip select and write enable are held low. It opens at whichever of the two falls last and closes at whichever rises first. The block holds the address and data seen on the last clock of the open window. On the first clock after the window closes, it stores them into the array once.

A fence input comes from a supply monitor. While it is high, every control, address and data input is ignored and the output drive is off. A write that is open when the fence rises is dropped, and nothing is stored. Reads return registered data one clock after the controls ask for them.

Top module: `wp_sram_ctrl`

## Requirements
- R1: While reset is low and on the first clock after it, `dout_oe` is 0 and `dout` is 0.
- R2: When an edge samples chip select low, output enable low, write enable high and fence low, then after that edge `dout_oe` is 1 and `dout` holds the array byte at the sampled address.
- R3: An edge that samples chip select high leaves `dout_oe` at 0 after it, whatever the other inputs are.
- R4: An edge that samples write enable low leaves `dout_oe` at 0 after it, even with chip select and output enable low.
- R5: A write window is the run of edges that sample chip select low, write enable low and fence low. On the first edge after the window that samples the fence low, the array location takes the data and address sampled on the window's last edge. Either control may fall first and either may rise first.
- R6: Data that changes during a window has no effect except for its value on the last edge of the window, and each window stores exactly one byte.
- R7: An edge that samples the fence high leaves `dout_oe` at 0 after it, and such edges never open or extend a write window.
- R8: If the fence is sampled high while a write window is open, the window is dropped and its location keeps its old content.
- R9: Only the low `ARR_AW` address bits select a location. Addresses that differ only above that bit reach the same byte.
- R10: A read sampled on the same edge that stores a write returns the location's content from before that store. The stored value is visible from the next read edge onwards.
- R11: Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_fence | input | 1 | Supply-monitor protect, active high |
| addr | input | ADDR_W (19) | Byte address |
| din | input | DATA_W (8) | Inbound half of the data bus |
| dout | output | DATA_W (8) | Outbound half of the data bus, 0 when not driven |
| dout_oe | output | 1 | Drive enable for the data bus pads |

## Verification
A wrong write-window state has two possible effects. If the window is stuck open, the store slips to a later edge with later data. If it is never opened, nothing is stored. Either way the first read-back of that location shows a wrong byte, and no other port shows the fault. A wrong drive-enable or a wrong read path shows on `dout_oe` or `dout` on the very next clock. For this reason, the reference model in the bench is compared on every cycle, and each store is followed by a read-back within a few cycles. This covers reads that fall on the same edge as a store and stores made to aliased addresses.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_WRITE,
    CYC_FENCED
  } cyc_e;

  // Classify the sampled bus controls; the fence overrides everything.
  function automatic cyc_e classify(input logic cs_n, input logic oe_n,
                                    input logic we_n, input logic fence);
    if (fence)      return CYC_FENCED;
    else if (cs_n)  return CYC_IDLE;
    else if (!we_n) return CYC_WRITE;
    else if (!oe_n) return CYC_READ;
    else            return CYC_IDLE;
  endfunction

endpackage

// File: rtl/wpsc_cycle.sv
module wpsc_cycle
  import wpsc_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int ARR_AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              fence,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              rd_req,
  output logic [ARR_AW-1:0] rd_addr,
  output logic              commit_vld,
  output logic [ARR_AW-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  localparam int DEPTH = 1 << ARR_AW;

  cyc_e              cyc;
  logic [ARR_AW-1:0] loc;
  logic              wr_open_q;
  logic [ARR_AW-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;

  assign cyc = classify(cs_n, oe_n, we_n, fence);

  // Location select: upper address bits fold onto the array.
  generate
    if (ARR_AW == ADDR_W) begin : g_full
      assign loc = addr;
    end else begin : g_alias
      logic [ADDR_W-1:0] masked;
      assign masked = addr & ADDR_W'(DEPTH - 1);
      assign loc    = ARR_AW'(masked);
    end
  endgenerate

  // Window tracking: the last sampled beat of an open window is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q  <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      wr_open_q <= (cyc == CYC_WRITE);
      if (cyc == CYC_WRITE) begin
        cap_addr_q <= loc;
        cap_data_q <= din;
      end
    end
  end

  // Window closed without a fence: store once. A fence drops the window.
  assign commit_vld  = wr_open_q && (cyc != CYC_WRITE) && (cyc != CYC_FENCED);
  assign commit_addr = cap_addr_q;
  assign commit_data = cap_data_q;

  assign rd_req  = (cyc == CYC_READ);
  assign rd_addr = loc;

endmodule

// File: rtl/wpsc_array.sv
module wpsc_array #(
  parameter int ARR_AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ARR_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wpsc_outreg.sv
module wpsc_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_req;
      dout    <= rd_req ? rd_data : '0;
    end
  end

endmodule

// File: rtl/wp_sram_ctrl.sv
module wp_sram_ctrl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_fence,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  logic              rd_req;
  logic [ARR_AW-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              commit_vld;
  logic [ARR_AW-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;

  wpsc_cycle #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .fence(pwr_fence), .addr(addr), .din(din),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  wpsc_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(commit_vld), .wr_addr(commit_addr), .wr_data(commit_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  wpsc_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_data(rd_data),
    .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: rtl/wpsc_checker.sv
module wpsc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              pwr_fence,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              commit_vld
);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && we_n && !pwr_fence) |=> dout_oe);

  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_oe);

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_oe);

  p_fence_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fence |=> !dout_oe);

  p_fence_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fence |-> !commit_vld);

  p_store_after_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> (cs_n || we_n));

  p_store_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |=> !commit_vld);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

endmodule

bind wp_sram_ctrl wpsc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .pwr_fence(pwr_fence), .dout(dout), .dout_oe(dout_oe), .commit_vld(commit_vld)
);

// File: tb/wp_sram_ctrl_tb.sv
`timescale 1ns/1ps
module wp_sram_ctrl_tb_top;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int SAW = 10;
  localparam int MASK = (1 << SAW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, fence = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] mref [int];
  logic          m_oe = 1'b0;
  logic [DW-1:0] m_dout = '0;
  logic          m_open = 1'b0;
  int            m_addr = 0;
  logic [DW-1:0] m_data = '0;

  always #4 clk = ~clk;

  wp_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ARR_AW(SAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_fence(fence), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set(input logic c, input logic o, input logic w, input logic f,
                     input int a, input logic [DW-1:0] d);
    cs_n = c; oe_n = o; we_n = w; fence = f; addr = AW'(a); din = d;
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic tick(input string tag);
    logic act, rdok;
    int   loc;
    @(posedge clk);
    act  = !cs_n && !we_n && !fence;
    rdok = !fence && !cs_n && !oe_n && we_n;
    loc  = int'(addr) & MASK;
    m_oe = rdok;
    m_dout = (rdok && mref.exists(loc)) ? mref[loc] : 8'h00;
    if (m_open && !act && !fence) mref[m_addr] = m_data;
    m_open = act;
    if (act) begin m_addr = loc; m_data = din; end
    @(negedge clk);
    chk({tag, " oe"}, 32'(dout_oe), 32'(m_oe));
    chk({tag, " data"}, 32'(dout), 32'(m_dout));
  endtask

  task automatic idle(input string tag);
    set(1, 1, 1, 0, 0, 8'h00);
    tick(tag);
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    set(0, 0, 1, 0, a, 8'h00);
    tick(tag);
    chk({tag, " readback"}, 32'(dout), 32'(exp));
    idle(tag);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input string tag);
    set(0, 1, 0, 0, a, d);
    tick(tag);
    tick(tag);
    set(0, 1, 1, 0, a, d);
    tick(tag);
    idle(tag);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R1 oe in reset", 32'(dout_oe), 0);
    chk("R1 data in reset", 32'(dout), 0);
    rst_n = 1'b1;
    idle("R1");

    // R5/R6: cs first, we later; data changes inside window, we rises first
    set(0, 1, 1, 0, 5, 8'h11); tick("R5");
    set(0, 1, 0, 0, 5, 8'h11); tick("R6");
    set(0, 1, 0, 0, 5, 8'h3C); tick("R6");
    set(0, 1, 1, 0, 5, 8'hEE); tick("R5");
    idle("R5");
    rd(5, 8'h3C, "R6");
    chk("R2 drive on read", 32'(dout_oe), 0);

    // R5: we first, cs later, cs rises first
    set(1, 1, 0, 0, 9, 8'hA5); tick("R5");
    set(0, 1, 0, 0, 9, 8'hA5); tick("R5");
    tick("R5");
    set(1, 1, 0, 0, 9, 8'h00); tick("R5");
    idle("R5");
    set(0, 0, 1, 0, 9, 8'h00); tick("R2");
    chk("R2 oe", 32'(dout_oe), 1);
    chk("R2 data", 32'(dout), 32'h0A5);
    idle("R2");

    // R10: read on the storing edge returns old data
    wr(20, 8'h10, "R10");
    set(0, 0, 0, 0, 20, 8'h77); tick("R10");
    set(0, 0, 1, 0, 20, 8'h00); tick("R10");
    chk("R10 old value", 32'(dout), 32'h10);
    tick("R10");
    chk("R10 new value", 32'(dout), 32'h77);
    idle("R10");

    // R9: aliasing above ARR_AW
    wr((1 << SAW) | 3, 8'h5A, "R9");
    rd(3, 8'h5A, "R9");
    rd((5 << SAW) | 3, 8'h5A, "R9");

    // R7: fence blocks read and write
    set(0, 0, 1, 1, 3, 8'h00); tick("R7");
    chk("R7 no drive", 32'(dout_oe), 0);
    set(0, 1, 0, 1, 3, 8'hFF); tick("R7"); tick("R7");
    set(1, 1, 1, 1, 3, 8'hFF); tick("R7");
    idle("R7");
    rd(3, 8'h5A, "R7");

    // R8: fence during an open window drops it
    set(0, 1, 0, 0, 9, 8'hEE); tick("R8");
    set(0, 1, 0, 1, 9, 8'hEE); tick("R8");
    set(1, 1, 1, 1, 9, 8'hEE); tick("R8");
    idle("R8");
    rd(9, 8'hA5, "R8");

    // R3/R11: deselected with oe low
    set(1, 0, 1, 0, 9, 8'h00); tick("R3");
    chk("R3 no drive", 32'(dout_oe), 0);
    chk("R11 zero", 32'(dout), 0);

    // R4: we low while reading shuts the drive
    set(0, 0, 1, 0, 9, 8'h00); tick("R4");
    set(0, 0, 0, 0, 9, 8'h42); tick("R4");
    chk("R4 drive off", 32'(dout_oe), 0);
    set(0, 0, 1, 0, 9, 8'h00); tick("R10");
    chk("R10 old on store edge", 32'(dout), 32'hA5);
    tick("R4");
    chk("R4 stored value", 32'(dout), 32'h42);
    idle("R4");

    // many back-to-back windows
    for (int i = 0; i < 40; i++) wr(100 + i, DW'(i * 7 + 1), "R5");
    for (int i = 0; i < 40; i++) rd(100 + i, DW'(i * 7 + 1), "R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule